// File: doc/BRIEF.md
# Two-Source Request/Acknowledge FIFO

This block is a single-clock first-in first-out queue. It holds `DEPTH` words of `WIDTH` bits. Two write buses feed it, and on every push a one-bit source select decides which of the two buses supplies the stored word. The other bus is not looked at.

Pushes and pops each use a request input and an acknowledge output. The acknowledge outputs are registered status flags, so a requester sees them before it commits to a transfer:

- `wr_ok` is high while the queue has room. A push takes place on a rising edge only when `wr_req` and `wr_ok` are both high.
- `rd_ok` is high while the queue holds at least one word. A pop takes place on a rising edge only when `rd_req` and `rd_ok` are both high.

The head of the queue is always shown on `dout`. Its value carries no meaning while `rd_ok` is low.

Top module: `dual_src_fifo`

## Requirements
- R1: While `rst` is high at a rising edge, the queue is emptied. After that edge `rd_ok` is 0 and `wr_ok` is 1.
- R2: A push with `src_sel` = 0 stores the value on `din_a`. The value on `din_b` has no effect on the stored word.
- R3: A push with `src_sel` = 1 stores the value on `din_b`. The value on `din_a` has no effect on the stored word.
- R4: Words come out on `dout` in the order they were accepted. While `rd_ok` is 1, `dout` equals the oldest word still held.
- R5: `wr_ok` is 0 exactly when `DEPTH` words are held. A push request while `wr_ok` is 0 is ignored: no word is stored and the queue contents do not change.
- R6: `rd_ok` is 0 exactly when no word is held. A pop request while `rd_ok` is 0 is ignored and changes no state.
- R7: A push and a pop in the same cycle, with both acknowledges high, leave the occupancy unchanged. `rd_ok` and `wr_ok` keep their values, and the pushed word joins the tail.
- R8: Without a pop request, `dout` holds its value while `rd_ok` is 1, even when a push is accepted in that cycle.
- R9: With `wr_req` low, nothing is stored whatever the write buses and `src_sel` carry.
- R10: Ordering is preserved across any number of wrap-arounds of the internal storage positions.
- R11: Both requests on a full queue perform only the pop. Both requests on an empty queue perform only the push.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Pop request |
| wr_req | input | 1 | Push request |
| rd_ok | output | 1 | Queue not empty; a requested pop is taken |
| wr_ok | output | 1 | Queue not full; a requested push is taken |
| src_sel | input | 1 | Write bus select: 0 picks `din_a`, 1 picks `din_b` |
| din_a | input | WIDTH | First write bus |
| din_b | input | WIDTH | Second write bus |
| dout | output | WIDTH | Word at the head of the queue |

## Verification
Every push drives different tagged values on the two buses, under both select values. The word that comes out therefore shows which bus was stored.

The queue is filled past its depth and drained past empty. Whether the surplus requests leave both the contents and the flags untouched then shows up at the ports.

Simultaneous push and pop is exercised in three states:
- partly full, where occupancy must stay the same;
- full, where only the pop may take effect;
- empty, where only the push may take effect.

A long alternating run drives the storage positions round many times, so any wrap error surfaces as a reordered word. Idle cycles with data held at the head separate a pop that leaks without a request from a correct hold.

// File: rtl/dq_pkg.sv
package dq_pkg;

  typedef enum logic {
    SRC_A = 1'b0,
    SRC_B = 1'b1
  } dq_src_e;

  function automatic int unsigned dq_idx_bits(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/dq_src_mux.sv
module dq_src_mux
  import dq_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             sel,
  input  logic [WIDTH-1:0] bus_a,
  input  logic [WIDTH-1:0] bus_b,
  output logic [WIDTH-1:0] picked
);

  dq_src_e src;

  always_comb begin
    src    = dq_src_e'(sel);
    picked = (src == SRC_B) ? bus_b : bus_a;
  end

endmodule

// File: rtl/dq_ctrl.sv
module dq_ctrl
  import dq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IW   = dq_idx_bits(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push_fire,
  output logic          pop_fire,
  output logic [IW-1:0] wr_idx,
  output logic [IW-1:0] rd_idx,
  output logic          has_data,
  output logic          has_room
);

  localparam bit           IS_POW2 = (DEPTH & (DEPTH - 1)) == 0;
  localparam logic [IW-1:0] LAST   = IW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC  = CW'(DEPTH);

  logic [CW-1:0] fill_q, fill_d;
  logic [IW-1:0] wr_nx, rd_nx;

  assign push_fire = push_req && has_room;
  assign pop_fire  = pop_req  && has_data;

  generate
    if (IS_POW2) begin : g_wrap_pow2
      assign wr_nx = wr_idx + 1'b1;
      assign rd_nx = rd_idx + 1'b1;
    end else begin : g_wrap_cmp
      assign wr_nx = (wr_idx == LAST) ? '0 : wr_idx + 1'b1;
      assign rd_nx = (rd_idx == LAST) ? '0 : rd_idx + 1'b1;
    end
  endgenerate

  always_comb begin
    fill_d = fill_q;
    case ({push_fire, pop_fire})
      2'b10:   fill_d = fill_q + 1'b1;
      2'b01:   fill_d = fill_q - 1'b1;
      default: fill_d = fill_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idx   <= '0;
      rd_idx   <= '0;
      fill_q   <= '0;
      has_data <= 1'b0;
      has_room <= 1'b1;
    end else begin
      if (push_fire) wr_idx <= wr_nx;
      if (pop_fire)  rd_idx <= rd_nx;
      fill_q   <= fill_d;
      has_data <= (fill_d != '0);
      has_room <= (fill_d != FULLC);
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!has_data && has_room));

  // R6
  empty_pop_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!has_data && !push_req) |=> (!has_data && $stable(rd_idx)));

  // R5
  full_push_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!has_room && !pop_req) |=> (!has_room && $stable(wr_idx)));

  // R7
  occupancy_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (push_req && pop_req && has_data && has_room)
      |=> ($stable(has_data) && $stable(has_room)));

  // R5
  flags_consistent_chk: assert property (@(posedge clk) disable iff (rst)
    (has_data || has_room));

  // R9
  no_push_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!push_req) |=> $stable(wr_idx));

endmodule

// File: rtl/dq_store.sv
module dq_store
  import dq_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  localparam int IW   = dq_idx_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IW-1:0]    widx,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IW-1:0]    ridx,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[widx] <= wdata;
  end

  assign rdata = cells[ridx];

endmodule

// File: rtl/dual_src_fifo.sv
module dual_src_fifo
  import dq_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_req,
  input  logic             wr_req,
  output logic             rd_ok,
  output logic             wr_ok,
  input  logic             src_sel,
  input  logic [WIDTH-1:0] din_a,
  input  logic [WIDTH-1:0] din_b,
  output logic [WIDTH-1:0] dout
);

  localparam int IW = dq_idx_bits(DEPTH);

  logic [WIDTH-1:0] wword;
  logic             push_fire, pop_fire;
  logic [IW-1:0]    wr_idx, rd_idx;

  dq_src_mux #(.WIDTH(WIDTH)) u_mux (
    .sel    (src_sel),
    .bus_a  (din_a),
    .bus_b  (din_b),
    .picked (wword)
  );

  dq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .push_req  (wr_req),
    .pop_req   (rd_req),
    .push_fire (push_fire),
    .pop_fire  (pop_fire),
    .wr_idx    (wr_idx),
    .rd_idx    (rd_idx),
    .has_data  (rd_ok),
    .has_room  (wr_ok)
  );

  dq_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (push_fire),
    .widx  (wr_idx),
    .wdata (wword),
    .ridx  (rd_idx),
    .rdata (dout)
  );

  // R8
  head_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && !rd_req) |=> (rd_ok && $stable(dout)));

  // R11
  full_both_pop_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_ok && rd_req && wr_req) |=> (wr_ok && $stable(wr_idx)));

endmodule

// File: tb/dual_src_fifo_tb.sv
`timescale 1ns/1ps
module dual_src_fifo_tb;

  localparam int W = 32;
  localparam int D = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         rd_req = 1'b0, wr_req = 1'b0, src_sel = 1'b0;
  logic [W-1:0] din_a = '0, din_b = '0;
  logic         rd_ok, wr_ok;
  logic [W-1:0] dout;

  int n_run  = 0;
  int n_fail = 0;
  int seq    = 0;
  bit done   = 1'b0;
  logic [W-1:0] mq[$];

  always #10 clk = ~clk;

  dual_src_fifo #(.WIDTH(W), .DEPTH(D)) u_dut (
    .clk(clk), .rst(rst), .rd_req(rd_req), .wr_req(wr_req),
    .rd_ok(rd_ok), .wr_ok(wr_ok), .src_sel(src_sel),
    .din_a(din_a), .din_b(din_b), .dout(dout)
  );

  task automatic chk(input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_outputs(input string tag);
    chk(tag, "rd_ok", W'(rd_ok), W'(mq.size() > 0));
    chk(tag, "wr_ok", W'(wr_ok), W'(mq.size() < D));
    if (mq.size() > 0) chk(tag, "dout", dout, mq[0]);
  endtask

  // Called at a falling edge: checks outputs, drives inputs, advances one cycle.
  task automatic step(input bit wv, input bit rv, input bit sv, input string tag);
    bit pushed, popped;
    check_outputs(tag);
    seq++;
    wr_req  = wv;
    rd_req  = rv;
    src_sel = sv;
    din_a   = 32'hA000_0000 + W'(seq);
    din_b   = 32'hB000_0000 + W'(seq);
    pushed  = wv && (mq.size() < D);
    popped  = rv && (mq.size() > 0);
    @(posedge clk);
    if (popped) void'(mq.pop_front());
    if (pushed) mq.push_back(sv ? din_b : din_a);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    wr_req = 0; rd_req = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mq.delete();
  endtask

  task automatic t_reset();
    do_reset();
    // R1
    chk("R1", "rd_ok after reset", W'(rd_ok), '0);
    chk("R1", "wr_ok after reset", W'(wr_ok), 1);
  endtask

  task automatic t_sel_a();
    for (int i = 0; i < 3; i++) step(1, 0, 0, "R2");
    for (int i = 0; i < 3; i++) step(0, 1, 0, "R4");
    check_outputs("R2");
  endtask

  task automatic t_sel_b();
    for (int i = 0; i < 3; i++) step(1, 0, 1, "R3");
    step(1, 0, 0, "R3");
    for (int i = 0; i < 4; i++) step(0, 1, 0, "R4");
    check_outputs("R3");
  endtask

  task automatic t_fill();
    for (int i = 0; i < D + 3; i++) step(1, 0, i[0], "R5");
    step(0, 0, 0, "R9");
    step(0, 0, 1, "R9");
    for (int i = 0; i < D + 1; i++) step(0, 1, 0, "R5");
    check_outputs("R5");
  endtask

  task automatic t_empty_pop();
    for (int i = 0; i < 3; i++) step(0, 1, 0, "R6");
    step(1, 0, 1, "R6");
    step(0, 1, 0, "R6");
    check_outputs("R6");
  endtask

  task automatic t_hold();
    step(1, 0, 0, "R8");
    for (int i = 0; i < 3; i++) step(0, 0, 1, "R8");
    step(1, 0, 1, "R8");
    step(0, 0, 0, "R8");
    step(0, 1, 0, "R8");
    step(0, 1, 0, "R8");
    check_outputs("R8");
  endtask

  task automatic t_simul();
    for (int i = 0; i < 3; i++) step(1, 0, 0, "R7");
    for (int i = 0; i < 5; i++) step(1, 1, i[0], "R7");
    for (int i = 0; i < 3; i++) step(0, 1, 0, "R7");
    check_outputs("R7");
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 5 * D; i++) step(1, i[0], i[1], "R10");
    for (int i = 0; i < D; i++) step(0, 1, 0, "R10");
    check_outputs("R10");
  endtask

  task automatic t_both_edges();
    step(1, 1, 1, "R11");
    step(0, 1, 0, "R11");
    for (int i = 0; i < D; i++) step(1, 0, 0, "R11");
    step(1, 1, 1, "R11");
    check_outputs("R11");
    for (int i = 0; i < D; i++) step(0, 1, 0, "R11");
    check_outputs("R11");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_sel_a();
    t_sel_b();
    t_fill();
    t_empty_pop();
    t_hold();
    t_simul();
    t_wrap();
    t_both_edges();
    // R1 again from a non-empty state
    step(1, 0, 0, "R1");
    do_reset();
    check_outputs("R1");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule